// File: doc/BRIEF.md
# Regular-Sampled Sinusoidal PWM Generator

This block drives one complementary pair of power-switch gates with a sinusoidal pulse-width pattern. A triangular carrier sweeps up and down over an 8-bit range. Once per carrier period, at the carrier minimum, the block takes one sample of a sine reference and holds it for the whole following period. The sine is rebuilt from a table that covers only a quarter of a wave. Each held sample is scaled by an 8-bit modulation index and centred on the carrier mid-scale. The main gate is high while the held value lies above the carrier.

A decimation setting can stretch the sampling interval to several carrier periods. This trades reference resolution for a lower update rate. The sine frequency is set by the carrier period multiplied by the 256 samples in one sine cycle and by the decimation factor.

Top module: `spwm_gen`

## Requirements
- R1: The carrier starts at 0 after reset and rises by one per clock up to 255. It then falls by one per clock back to 0, so one carrier period is 510 clocks.
- R2: The held reference changes only on a clock edge at which the carrier is 0. A change of the modulation index during a carrier period has no effect on that period's pulse.
- R3: The quarter table has 64 entries, mag(a) = round(255·sin(2π(a+0.5)/256)). An 8-bit phase selects the table entry. When phase bit 6 is set, the address is 63 minus phase bits 5:0; otherwise it is bits 5:0. When phase bit 7 is set, the sample is negative.
- R4: The reference is h = 128 + floor(mag·M/256) for a positive sample and h = 128 − floor(mag·M/256) for a negative one, clamped to 0..255. M is the modulation index.
- R5: The main gate is registered and equals (held reference > carrier), one clock late. Over a full carrier period it is high for 2h−1 clocks when h ≥ 1 and for 0 clocks when h = 0.
- R6: The second gate is always the inverse of the main gate outside reset. Both gates are low while the active-low reset is asserted.
- R7: With decimation setting k, a sample is taken at the first carrier minimum after reset and then at every (k+1)-th minimum. The phase advances by one for each sample taken, starting from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modIdx | input | 8 | Modulation index M, 0..255 |
| decimSel | input | 4 | Decimation k: one sample every k+1 carrier periods |
| gateHi | output | 1 | Main switch gate |
| gateLo | output | 1 | Complementary switch gate |

## Verification
The bench counts the high clocks of the main gate over each 510-clock carrier window and compares the count with 2h−1. This is done for every one of the 256 phases at full modulation, so all four quadrants are covered. A wrong mirror or wrong sign shows up as a count that is off in one quadrant. A missing clamp shows up as a count that wraps near the peaks. It also changes the modulation index halfway through a carrier window: a design that samples outside the carrier minimum would bend that window's count. A decimated run checks that the phase repeats for k+1 windows, which an off-by-one in the period counter would break. The gate pair is checked for inverse levels on every clock and for low levels during reset.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  typedef struct packed {
    logic atNadir;     // carrier is at its minimum this cycle
    logic sampleSlot;  // this minimum is a sampling slot under decimation
  } spwmStrobe_t;

  // Magnitude of quarter-wave entry idx, centred on half steps so the
  // mirrored half-wave is an exact reversal of the stored quarter.
  function automatic int quarterMag(input int idx, input int addrW, input int magW);
    real ang;
    real fullScale;
    ang = 2.0 * 3.14159265358979 * (real'(idx) + 0.5) / (4.0 * real'(1 << addrW));
    fullScale = real'((1 << magW) - 1);
    return $rtoi(fullScale * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/spwm_ctrl.sv
module spwm_ctrl
  import spwm_pkg::*;
#(
  parameter int CAR_W = 8,
  parameter int DEC_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DEC_W-1:0] decimSel,
  output logic [CAR_W-1:0] carrier,
  output spwmStrobe_t      strobe
);

  localparam logic [CAR_W-1:0] CAR_TOP = '1;
  localparam logic [CAR_W-1:0] CAR_ONE = CAR_W'(1);

  logic             goingUp;
  logic [DEC_W-1:0] decCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carrier <= '0;
      goingUp <= 1'b1;
    end else if (goingUp) begin
      carrier <= carrier + CAR_ONE;
      if (carrier == CAR_TOP - CAR_ONE) goingUp <= 1'b0;
    end else begin
      carrier <= carrier - CAR_ONE;
      if (carrier == CAR_ONE) goingUp <= 1'b1;
    end
  end

  // Counts carrier minima; slot 0 is the sampling slot.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decCnt <= '0;
    end else if (strobe.atNadir) begin
      if (decCnt >= decimSel) decCnt <= '0;
      else                    decCnt <= decCnt + DEC_W'(1);
    end
  end

  always_comb begin
    strobe.atNadir    = (carrier == '0);
    strobe.sampleSlot = (decCnt == '0);
  end

endmodule

// File: rtl/spwm_dp.sv
module spwm_dp
  import spwm_pkg::*;
#(
  parameter int CAR_W  = 8,
  parameter int MAG_W  = 8,
  parameter int LUT_AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MAG_W-1:0]  modIdx,
  input  logic [CAR_W-1:0]  carrier,
  input  spwmStrobe_t       strobe,
  output logic [CAR_W-1:0]  heldRef,
  output logic [LUT_AW+1:0] phase,
  output logic              gateHi,
  output logic              gateLo
);

  localparam int PH_W  = LUT_AW + 2;
  localparam int DEPTH = 1 << LUT_AW;
  localparam int SUM_W = ((CAR_W > MAG_W) ? CAR_W : MAG_W) + 2;
  localparam logic [CAR_W-1:0] CAR_TOP = '1;
  localparam logic [CAR_W-1:0] CAR_MID = CAR_W'(1 << (CAR_W - 1));

  logic [MAG_W-1:0]   quarterLut [DEPTH];
  logic [LUT_AW-1:0]  lutAddr;
  logic               negHalf;
  logic [2*MAG_W-1:0] prod;
  logic [MAG_W-1:0]   scaled;
  logic [SUM_W-1:0]   scaledW, midW, topW;
  logic [CAR_W-1:0]   refNext;
  logic               aboveCarrier;
  logic               takeNow;

  for (genvar g = 0; g < DEPTH; g++) begin : g_lut
    assign quarterLut[g] = MAG_W'(quarterMag(g, LUT_AW, MAG_W));
  end

  always_comb begin
    lutAddr = phase[PH_W-2] ? ~phase[LUT_AW-1:0] : phase[LUT_AW-1:0];
    negHalf = phase[PH_W-1];
    prod    = quarterLut[lutAddr] * modIdx;
    scaled  = prod[2*MAG_W-1:MAG_W];
    scaledW = SUM_W'(scaled);
    midW    = SUM_W'(CAR_MID);
    topW    = SUM_W'(CAR_TOP);
    if (negHalf) begin
      refNext = (scaledW >= midW) ? '0 : CAR_W'(midW - scaledW);
    end else begin
      refNext = ((midW + scaledW) > topW) ? CAR_TOP : CAR_W'(midW + scaledW);
    end
    takeNow      = strobe.atNadir && strobe.sampleSlot;
    aboveCarrier = (heldRef > carrier);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldRef <= CAR_MID;
      phase   <= '0;
    end else if (takeNow) begin
      heldRef <= refNext;
      phase   <= phase + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateHi <= 1'b0;
      gateLo <= 1'b0;
    end else begin
      gateHi <= aboveCarrier;
      gateLo <= !aboveCarrier;
    end
  end

endmodule

// File: rtl/spwm_gen.sv
module spwm_gen
  import spwm_pkg::*;
#(
  parameter int CAR_W  = 8,
  parameter int MAG_W  = 8,
  parameter int LUT_AW = 6,
  parameter int DEC_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [MAG_W-1:0] modIdx,
  input  logic [DEC_W-1:0] decimSel,
  output logic             gateHi,
  output logic             gateLo
);

  logic [CAR_W-1:0]  carrier;
  logic [CAR_W-1:0]  heldRef;
  logic [LUT_AW+1:0] phase;
  spwmStrobe_t       strobe;

  spwm_ctrl #(.CAR_W(CAR_W), .DEC_W(DEC_W)) ctrlU (
    .clk      (clk),
    .rstN     (rstN),
    .decimSel (decimSel),
    .carrier  (carrier),
    .strobe   (strobe)
  );

  spwm_dp #(.CAR_W(CAR_W), .MAG_W(MAG_W), .LUT_AW(LUT_AW)) dpU (
    .clk     (clk),
    .rstN    (rstN),
    .modIdx  (modIdx),
    .carrier (carrier),
    .strobe  (strobe),
    .heldRef (heldRef),
    .phase   (phase),
    .gateHi  (gateHi),
    .gateLo  (gateLo)
  );

endmodule

// File: rtl/spwm_gen_chk.sv
module spwm_gen_chk #(
  parameter int CAR_W  = 8,
  parameter int LUT_AW = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [CAR_W-1:0]  carrier,
  input logic [CAR_W-1:0]  heldRef,
  input logic [LUT_AW+1:0] phase,
  input logic              gateHi,
  input logic              gateLo
);

  localparam logic [CAR_W-1:0] CAR_TOP = '1;
  localparam logic [CAR_W-1:0] CAR_ONE = CAR_W'(1);

  // R1: carrier moves by exactly one step every clock
  a_r1_carrier_step: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((carrier == $past(carrier) + CAR_ONE) || (carrier == $past(carrier) - CAR_ONE)));

  // R1: turn-around at the top
  a_r1_peak_turn: assert property (@(posedge clk) disable iff (!rstN)
    (carrier == CAR_TOP) |=> (carrier == CAR_TOP - CAR_ONE));

  // R1: turn-around at the bottom
  a_r1_nadir_turn: assert property (@(posedge clk) disable iff (!rstN)
    (carrier == '0) |=> (carrier == CAR_ONE));

  // R2: held reference only moves after a carrier minimum
  a_r2_hold_mid_period: assert property (@(posedge clk) disable iff (!rstN)
    (carrier != '0) |=> $stable(heldRef));

  // R7: phase only advances after a carrier minimum
  a_r7_phase_hold: assert property (@(posedge clk) disable iff (!rstN)
    (carrier != '0) |=> $stable(phase));

  // R6: gates are inverse outside reset
  a_r6_complement: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (gateHi != gateLo));

  // R6: both gates low in reset
  a_r6_reset_low: assert property (@(posedge clk)
    !rstN |-> (!gateHi && !gateLo));

endmodule

bind spwm_gen spwm_gen_chk #(.CAR_W(CAR_W), .LUT_AW(LUT_AW)) chkU (
  .clk     (clk),
  .rstN    (rstN),
  .carrier (carrier),
  .heldRef (heldRef),
  .phase   (phase),
  .gateHi  (gateHi),
  .gateLo  (gateLo)
);

// File: tb/spwm_gen_tb.sv
module spwm_gen_tb_top;

  localparam int PERIOD = 510;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] modIdx = 8'd0;
  logic [3:0] decimSel = 4'd0;
  logic       gateHi, gateLo;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  spwm_gen dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .modIdx   (modIdx),
    .decimSel (decimSel),
    .gateHi   (gateHi),
    .gateLo   (gateLo)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected high clocks per carrier window for a given phase and index.
  function automatic int expHigh(input int ph, input int m);
    real s;
    int mag, sc, h;
    s   = $sin(2.0 * 3.14159265358979 * (real'(ph % 256) + 0.5) / 256.0);
    mag = $rtoi(255.0 * ((s < 0.0) ? -s : s) + 0.5);
    sc  = (mag * m) / 256;
    h   = ((ph % 256) >= 128) ? 128 - sc : 128 + sc;
    if (h < 0)   h = 0;
    if (h > 255) h = 255;
    return (h == 0) ? 0 : 2 * h - 1;
  endfunction

  // Reset with given settings; returns right after the first active edge.
  task automatic doReset(input int m, input int k);
    rstN     = 1'b0;
    modIdx   = 8'(m);
    decimSel = 4'(k);
    repeat (3) @(negedge clk);
    check("R6 gateHi low in reset", int'(gateHi), 0);
    check("R6 gateLo low in reset", int'(gateLo), 0);
    rstN = 1'b1;
    @(posedge clk);
  endtask

  // One carrier window; optionally changes modIdx after clock changeAt.
  task automatic runWindow(input int changeAt, input int newM,
                           output int highs, output int compErr);
    highs   = 0;
    compErr = 0;
    for (int c = 1; c <= PERIOD; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (gateHi) highs++;
      if (gateHi == gateLo) compErr++;
      if (c == changeAt) modIdx = 8'(newM);
    end
  endtask

  task automatic testFullSweep();
    int highs, ce, ceTotal;
    ceTotal = 0;
    doReset(255, 0);
    for (int p = 0; p < 256; p++) begin
      runWindow(0, 0, highs, ce);
      ceTotal += ce;
      // R3 R4 R5 R1: every phase, all quadrants, clamp at peaks
      check($sformatf("R3/R4/R5 sweep phase %0d", p), highs, expHigh(p, 255));
    end
    check("R6 complement over sweep", ceTotal, 0);
  endtask

  task automatic testHold();
    int highs, ce;
    doReset(255, 0);
    runWindow(200, 0, highs, ce);
    check("R2 index change mid-period ignored", highs, expHigh(0, 255));
    runWindow(0, 0, highs, ce);
    check("R2 new index taken at next minimum", highs, expHigh(1, 0));
    check("R6 complement in hold test", ce, 0);
  endtask

  task automatic testZeroIndex();
    int highs, ce;
    doReset(0, 0);
    for (int w = 0; w < 3; w++) begin
      runWindow(0, 0, highs, ce);
      check($sformatf("R4 zero index window %0d", w), highs, 255);
    end
  endtask

  task automatic testDecim();
    int highs, ce;
    doReset(128, 2);
    for (int w = 0; w < 7; w++) begin
      runWindow(0, 0, highs, ce);
      check($sformatf("R7 decimation k=2 window %0d", w), highs, expHigh(w / 3, 128));
    end
    doReset(200, 1);
    for (int w = 0; w < 4; w++) begin
      runWindow(0, 0, highs, ce);
      check($sformatf("R7 decimation k=1 window %0d", w), highs, expHigh(w / 2, 200));
    end
  endtask

  initial begin
    testZeroIndex();
    testHold();
    testDecim();
    testFullSweep();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule